// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block produces the four gate-drive signals of a full-bridge power stage. The bridge has two legs, and each leg is driven by a complementary high/low pair. The first leg (AB) toggles at fixed points of a free-running switching period. The second leg (CD) toggles at the same nominal 50% duty, but it lags the first leg by an amount set by a phase command word. Power delivered to the load is controlled only by that lag; the duty of each leg does not change.

Before every turn-on, each leg inserts a dead-time in which both of its switches are low. This gives the resonant transition time to complete. The two legs take separate dead-time settings. The dead-time cannot be switched off: a zero setting is raised to a parameter minimum, and large settings are capped at a parameter maximum.

A force-off input drops all four gates at the next clock. Switching restarts cleanly at the next period boundary after force-off is released. A tick input gates all timing, so the period and dead-times are counted in tick-qualified cycles.

Top module: `psfb_gate_gen`

## Requirements
- R1: The two outputs of a leg are never high together. Each output is high for at most N/2 ticks of an N-tick period (default N=16).
- R2: The level of leg AB is high while the period position is below N/2 and low otherwise. Each gate output follows the leg level one clock after its dead-time has elapsed.
- R3: The CD leg lags AB by L = floor(cmd*(N/2)/2^W) ticks, where cmd is the W-bit phase command (default W=8). The all-ones command gives exactly L = N/2, a lag of 180 degrees.
- R4: A phase command below ZERO_LVL (default 48) forces L = 0, even where the formula in R3 would give a non-zero lag (for example, cmd=40 gives 0 while cmd=48 gives 1).
- R5: The phase command is taken only on the tick that ends a period (position N-1). Changes at other times have no effect on CD until the next period.
- R6: After each toggle of a leg level, both outputs of that leg stay low for exactly D ticks. D is derived from that leg's own dead-time word, so the two legs are independent.
- R7: Dead-time clamp: a setting below DT_MIN (default 1, so 0 is included) uses DT_MIN, and a setting above DT_MAX (default 6) uses DT_MAX.
- R8: While force-off is high at a clock edge, all four outputs are low after that edge, whatever the state of tick or of any pending edge.
- R9: After reset or after force-off is released, outputs stay low until the next period start (position 0). The first turn-on of each leg then follows a full dead-time.
- R10: The period position, the phase sampling and the dead-time counts advance only on clocks with tick high. Otherwise the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable; one switching time step per high cycle |
| kill | input | 1 | Force-off, all gates low |
| phase_cmd | input | PH_W | Phase lag command of leg CD (0 = no lag, all ones = 180 degrees) |
| dt_ab | input | DT_W | Dead-time setting of leg AB in ticks |
| dt_cd | input | DT_W | Dead-time setting of leg CD in ticks |
| ab_hi | output | 1 | Leg AB high-side gate |
| ab_lo | output | 1 | Leg AB low-side gate |
| cd_hi | output | 1 | Leg CD high-side gate |
| cd_lo | output | 1 | Leg CD low-side gate |

## Verification
The hardest situation to reach is a CD level toggle that lands while that leg is still inside its dead-time. The same difficulty applies to a resume in which CD has no level change at the period start but still owes a full dead-time. The stimulus reaches these cases in two ways. It switches the phase command between lags whose CD edges fall close to the period boundary, so the new lag takes effect right at a wrap. It also releases force-off with different dead-times on the two legs while ticks are sparse. A cycle-by-cycle reference model, built from run lengths of each leg level, then predicts every gate.

// File: rtl/psfb_pkg.sv
`timescale 1ns/1ps
package psfb_pkg;

    // Drive pair of one bridge leg
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drive_t;

    localparam int unsigned LEG_AB   = 0;
    localparam int unsigned LEG_CD   = 1;
    localparam int unsigned NUM_LEGS = 2;

    // Dead-time can never be zero: bound the request into [lo_lim, hi_lim]
    function automatic int unsigned clamp_dead(int unsigned req,
                                               int unsigned lo_lim,
                                               int unsigned hi_lim);
        if (req < lo_lim) return lo_lim;
        if (req > hi_lim) return hi_lim;
        return req;
    endfunction

    // Phase command to lag in ticks, with zero-phase dead zone and full-scale
    function automatic int unsigned phase_to_lag(int unsigned cmd,
                                                 int unsigned cmd_w,
                                                 int unsigned half,
                                                 int unsigned zero_lvl);
        int unsigned full;
        full = (32'd1 << cmd_w) - 32'd1;
        if (cmd < zero_lvl) return 0;
        if (cmd >= full) return half;
        return (cmd * half) >> cmd_w;
    endfunction

endpackage

// File: rtl/psfb_period_timer.sv
`timescale 1ns/1ps
module psfb_period_timer
    import psfb_pkg::*;
#(
    parameter int unsigned PERIOD   = 16,
    parameter int unsigned PH_W     = 8,
    parameter int unsigned ZERO_LVL = 48
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        kill,
    input  logic [PH_W-1:0]             phase_cmd,
    output logic [$clog2(PERIOD)-1:0]   pos,
    output logic                        halt,
    output logic [NUM_LEGS-1:0]         leg_lvl
);
    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam int unsigned HALF  = PERIOD / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] lag_q;
    logic [CNT_W-1:0] lag_d;
    logic [CNT_W:0]   lag_pos;
    logic             wrap;

    assign wrap  = tick && (pos == LAST);
    assign lag_d = CNT_W'(phase_to_lag(32'(phase_cmd), PH_W, HALF, ZERO_LVL));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            lag_q <= '0;
            halt  <= 1'b1;
        end else begin
            if (tick) pos <= wrap ? '0 : pos + 1'b1;
            // new lag only at the period boundary
            if (wrap) lag_q <= lag_d;
            if (kill)      halt <= 1'b1;
            else if (wrap) halt <= 1'b0;
        end
    end

    always_comb begin
        if (pos >= lag_q) lag_pos = {1'b0, pos - lag_q};
        else              lag_pos = {1'b0, pos} + (CNT_W+1)'(PERIOD) - {1'b0, lag_q};
        leg_lvl[LEG_AB] = (pos < CNT_W'(HALF));
        leg_lvl[LEG_CD] = (lag_pos < (CNT_W+1)'(HALF));
    end

endmodule

// File: rtl/psfb_deadband.sv
`timescale 1ns/1ps
module psfb_deadband
    import psfb_pkg::*;
#(
    parameter int unsigned DT_W   = 4,
    parameter int unsigned DT_MIN = 1,
    parameter int unsigned DT_MAX = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            run,
    input  logic            level,
    input  logic [DT_W-1:0] dt_cfg,
    output leg_drive_t      drv
);
    localparam int unsigned DC_W = $clog2(DT_MAX + 1);

    logic [DC_W-1:0] dt_eff;
    logic [DC_W-1:0] wait_q;
    logic            lvl_q;

    assign dt_eff = DC_W'(clamp_dead(32'(dt_cfg), DT_MIN, DT_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            drv    <= '0;
            wait_q <= '0;
            lvl_q  <= 1'b0;
        end else if (!run) begin
            // held off: track level, owe a full dead-time on restart
            drv    <= '0;
            wait_q <= dt_eff;
            lvl_q  <= level;
        end else if (tick) begin
            if (level != lvl_q) begin
                lvl_q  <= level;
                wait_q <= dt_eff - 1'b1;
                drv    <= '0;
            end else if (wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
                drv    <= '0;
            end else begin
                drv.hi <= level;
                drv.lo <= ~level;
            end
        end
    end

endmodule

// File: rtl/psfb_gate_gen.sv
`timescale 1ns/1ps
module psfb_gate_gen
    import psfb_pkg::*;
#(
    parameter int unsigned PERIOD   = 16,
    parameter int unsigned PH_W     = 8,
    parameter int unsigned ZERO_LVL = 48,
    parameter int unsigned DT_W     = 4,
    parameter int unsigned DT_MIN   = 1,
    parameter int unsigned DT_MAX   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            kill,
    input  logic [PH_W-1:0] phase_cmd,
    input  logic [DT_W-1:0] dt_ab,
    input  logic [DT_W-1:0] dt_cd,
    output logic            ab_hi,
    output logic            ab_lo,
    output logic            cd_hi,
    output logic            cd_lo
);
    localparam int unsigned CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0]    pos;
    logic                halt;
    logic [NUM_LEGS-1:0] leg_lvl;
    logic [DT_W-1:0]     dt_sel [NUM_LEGS];
    leg_drive_t          drv    [NUM_LEGS];
    logic                run;

    assign dt_sel[LEG_AB] = dt_ab;
    assign dt_sel[LEG_CD] = dt_cd;
    assign run = !halt && !kill;

    psfb_period_timer #(
        .PERIOD  (PERIOD),
        .PH_W    (PH_W),
        .ZERO_LVL(ZERO_LVL)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .kill     (kill),
        .phase_cmd(phase_cmd),
        .pos      (pos),
        .halt     (halt),
        .leg_lvl  (leg_lvl)
    );

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            psfb_deadband #(
                .DT_W  (DT_W),
                .DT_MIN(DT_MIN),
                .DT_MAX(DT_MAX)
            ) u_db (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .run   (run),
                .level (leg_lvl[g]),
                .dt_cfg(dt_sel[g]),
                .drv   (drv[g])
            );
        end
    endgenerate

    assign ab_hi = drv[LEG_AB].hi;
    assign ab_lo = drv[LEG_AB].lo;
    assign cd_hi = drv[LEG_CD].hi;
    assign cd_lo = drv[LEG_CD].lo;

endmodule

// File: rtl/psfb_gate_chk.sv
`timescale 1ns/1ps
module psfb_gate_chk #(
    parameter int unsigned PERIOD = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      kill,
    input logic                      ab_hi,
    input logic                      ab_lo,
    input logic                      cd_hi,
    input logic                      cd_lo,
    input logic [$clog2(PERIOD)-1:0] pos,
    input logic                      halt
);
    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(PERIOD / 2);

    assert_pair_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(ab_hi && ab_lo) && !(cd_hi && cd_lo));

    assert_ab_align_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ab_hi) |-> (pos <= HALF_POS));

    assert_gap_ab_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(ab_hi) |-> !$past(ab_lo)) and ($rose(ab_lo) |-> !$past(ab_hi)));

    assert_gap_cd_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cd_hi) |-> !$past(cd_lo)) and ($rose(cd_lo) |-> !$past(cd_hi)));

    assert_force_off_R8: assert property (@(posedge clk) disable iff (rst)
        kill |=> !(ab_hi || ab_lo || cd_hi || cd_lo));

    assert_resume_start_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> (pos == '0));

endmodule

bind psfb_gate_gen psfb_gate_chk #(.PERIOD(PERIOD)) u_gate_chk (
    .clk  (clk),
    .rst  (rst),
    .kill (kill),
    .ab_hi(ab_hi),
    .ab_lo(ab_lo),
    .cd_hi(cd_hi),
    .cd_lo(cd_lo),
    .pos  (pos),
    .halt (halt)
);

// File: tb/tb_psfb_gate_gen.sv
`timescale 1ns/1ps
module tb_psfb_gate_gen;
    localparam int N    = 16;
    localparam int HALF = 8;
    localparam int PW   = 8;
    localparam int ZL   = 48;
    localparam int DMIN = 1;
    localparam int DMAX = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       kill = 1'b0;
    logic [7:0] phase_cmd = 8'd0;
    logic [3:0] dt_ab = 4'd1;
    logic [3:0] dt_cd = 4'd1;
    logic       ab_hi, ab_lo, cd_hi, cd_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [3:0] v;
        int         due;
        string      tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    int   m_cnt = 0, m_shift = 0, run_a = 0, run_c = 0;
    bit   m_halt = 1'b1, prev_a = 1'b0, prev_c = 1'b0;
    logic [3:0] m_out = 4'b0;

    psfb_gate_gen dut (
        .clk(clk), .rst(rst), .tick(tick), .kill(kill), .phase_cmd(phase_cmd),
        .dt_ab(dt_ab), .dt_cd(dt_cd),
        .ab_hi(ab_hi), .ab_lo(ab_lo), .cd_hi(cd_hi), .cd_lo(cd_lo)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // R7: dead-time bound
    function automatic int dead_of(input int s);
        return (s < DMIN) ? DMIN : ((s > DMAX) ? DMAX : s);
    endfunction

    // R3 / R4: lag in ticks from the command
    function automatic int lag_of(input int c);
        if (c < ZL) return 0;
        if (c == (1 << PW) - 1) return HALF;
        return (c * HALF) / (1 << PW);
    endfunction

    task automatic step(input bit t, input bit k, input int ph,
                        input int da_set, input int dc_set, input string tag);
        bit la, lc;
        int da, dc;
        exp_t e;
        @(negedge clk);
        tick = t; kill = k; phase_cmd = 8'(ph); dt_ab = 4'(da_set); dt_cd = 4'(dc_set);
        la = (m_cnt < HALF);
        lc = (((m_cnt - m_shift + N) % N) < HALF);
        da = dead_of(da_set);
        dc = dead_of(dc_set);
        if (k || m_halt) begin
            m_out = 4'b0; run_a = 0; run_c = 0; prev_a = la; prev_c = lc;
        end else if (t) begin
            if (la != prev_a) run_a = 1; else if (run_a < 1000) run_a++;
            if (lc != prev_c) run_c = 1; else if (run_c < 1000) run_c++;
            prev_a = la; prev_c = lc;
            m_out = {la && (run_a > da), !la && (run_a > da),
                     lc && (run_c > dc), !lc && (run_c > dc)};
        end
        if (k) m_halt = 1'b1;
        else if (t && m_cnt == N - 1) m_halt = 1'b0;
        if (t && m_cnt == N - 1) m_shift = lag_of(ph);
        if (t) m_cnt = (m_cnt + 1) % N;
        e.v = m_out; e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run_n(input int n, input int ph, input int da, input int dc,
                         input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, ph, da, dc, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        logic [3:0] act;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            act = {ab_hi, ab_lo, cd_hi, cd_lo};
            checks++;
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s at cycle %0d: {ab_hi,ab_lo,cd_hi,cd_lo} actual=%b expected=%b",
                         e.tag, cyc, act, e.v);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({ab_hi, ab_lo, cd_hi, cd_lo} !== 4'b0) begin
            errors++;
            $display("FAIL R9 reset: actual=%b expected=0000", {ab_hi, ab_lo, cd_hi, cd_lo});
        end
        rst = 1'b0;

        // R1 R2 R3 R6 R9: quarter lag, distinct dead-times
        run_n(56, 128, 2, 3, "R1 R2 R3 R6 R9 lag4");
        // R5: command changes mid-period, taken only at the wrap
        run_n(5, 128, 2, 3, "R5 pre");
        run_n(40, 255, 2, 3, "R3 R5 full-scale lag");
        // lag that puts CD edges near the boundary, then back to zero
        run_n(32, 230, 2, 3, "R3 R6 lag7");
        run_n(32, 40, 2, 3, "R4 below zero level");
        run_n(32, 48, 2, 3, "R3 R4 at zero level");
        // R8: force-off mid-period, dead-time changed while off
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 48, 0, 15, "R8 force-off");
        run_n(50, 200, 0, 15, "R7 R9 clamped dead-time resume");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 200, 6, 1, "R8 force-off");
        run_n(50, 100, 6, 1, "R6 R9 independent legs");
        // R10: sparse ticks, force-off on a non-tick cycle
        for (int i = 0; i < 90; i++) step(i % 3 != 0, 1'b0, 160, 3, 2, "R10 sparse tick");
        step(1'b0, 1'b1, 160, 3, 2, "R8 R10 force-off without tick");
        for (int i = 0; i < 70; i++) step(i % 2 == 0, 1'b0, 160, 3, 2, "R9 R10 resume");
        run_n(40, 0, 1, 1, "R1 R4 zero lag minimum dead-time");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule